// File: doc/BRIEF.md
# Character-Cell Display Generator

This block turns a small text screen into a raster video signal. It holds a grid of character cells in internal display memory, 80 columns by 25 rows by default. Each cell keeps a 7-bit character code and a 6-bit colour attribute. From a single 25 MHz pixel clock it produces active-low horizontal and vertical sync pulses and a 3-bit RGB pixel stream. The active picture is 640 by 400 pixels inside a total raster of 800 by 450 pixels.

A host drives a narrow write-only register port. A write places a character or an attribute at the cursor. Other writes move the cursor column and row, or set a row display offset. The offset gives hardware scrolling: screen row `s` shows memory row `(s + offset) mod ROWS`. The block forms this sum one bit wider than a row index and then wraps it with a single conditional subtract, so the wrap stays correct for every in-range pair.

Each cell is 8 pixels by 16 scan lines. The glyph itself covers 7 columns and 11 lines, and the rest of the cell shows the background colour. Glyph rows come from a generator function in the shared package, which stands in for a full font.

Top module: `vdu_top`

## Requirements
- R1: The line period is H_TOTAL pixel clocks (800 by default). `hsync_n` is low for HS_LEN clocks, starting HS_START clocks after the first visible pixel of the line.
- R2: The frame period is V_TOTAL lines (450 by default). `vsync_n` is low for VS_LEN whole lines, starting at the first clock of line VS_START.
- R3: `rgb` is 0 outside the active area. The active area is the first COLS*8 clocks of each line, on the first ROWS*16 lines of the frame.
- R4: Screen character row `s` shows display memory row `(s + offset) mod ROWS`, for every offset from 0 to ROWS-1.
- R5: The register select codes are: 0 writes the character code at the cursor (data bit 7 is ignored); 1 writes the attribute at the cursor (data bits 7:6 are ignored); 2 sets the cursor column; 3 sets the cursor row; 4 sets the row offset. Codes 5 to 7 have no effect.
- R6: A cursor column write of COLS or more is ignored. A cursor row or offset write of ROWS or more is ignored. In each case the register keeps its old value.
- R7: In cell pixel column `p` (0 to 7) of cell scan line `r` (0 to 15) for character `k`, the glyph row is `k XOR r` for `r < 11` and 0 otherwise. Pixel `p < 7` is lit when bit `6-p` of the glyph row is set. Column 7 is never lit.
- R8: Attribute bits are 5 fg red, 4 fg green, 3 fg blue, 2 bg red, 1 bg green, 0 bg blue. A lit pixel shows the foreground triple and an unlit pixel shows the background triple, with `rgb[2]` red, `rgb[1]` green and `rgb[0]` blue. An attribute write leaves the character code unchanged.
- R9: During reset, `hsync_n` and `vsync_n` are 1 and `rgb` is 0. After reset, the cursor column, cursor row and offset are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (25 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_sel | input | 3 | Register select code |
| reg_data | input | 8 | Register write data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 3 | Pixel colour: red, green, blue |

## Verification
Some properties are checked on every clock: the spacing of successive sync falling edges, the length of each horizontal pulse, black output whenever either sync is low, the scrolled memory row staying below ROWS, and the cursor and offset registers staying in range. Whether the right glyph and colours reach the right screen position cannot be seen one cycle at a time. The bench therefore captures whole frames under several offsets, including an ignored out-of-range offset write, and compares every active pixel against a model built from the requirements. Those scenarios also show the effect of rejected cursor writes, the masked data bits, and an attribute-only write.

// File: rtl/vdu_pkg.sv
`timescale 1ns/1ps
package vdu_pkg;
  localparam int CELL_W  = 8;
  localparam int CELL_H  = 16;
  localparam int GLYPH_W = 7;
  localparam int GLYPH_H = 11;

  typedef enum logic [2:0] {
    SEL_CHAR = 3'd0,
    SEL_ATTR = 3'd1,
    SEL_COL  = 3'd2,
    SEL_ROW  = 3'd3,
    SEL_OFFS = 3'd4
  } reg_sel_e;

  // bit 5 down to bit 0
  typedef struct packed {
    logic fg_r;
    logic fg_g;
    logic fg_b;
    logic bg_r;
    logic bg_g;
    logic bg_b;
  } attr_t;

  // Test glyph generator: 128 codes, GLYPH_H lines, GLYPH_W bits per line.
  function automatic logic [GLYPH_W-1:0] glyph_row(input logic [6:0] code,
                                                   input logic [3:0] line);
    if (int'(line) < GLYPH_H) return code ^ {3'b000, line};
    else                      return '0;
  endfunction
endpackage

// File: rtl/vdu_timing.sv
`timescale 1ns/1ps
module vdu_timing #(
  parameter int H_TOTAL  = 800,
  parameter int H_ACTIVE = 640,
  parameter int HS_START = 656,
  parameter int HS_LEN   = 96,
  parameter int V_TOTAL  = 450,
  parameter int V_ACTIVE = 400,
  parameter int VS_START = 412,
  parameter int VS_LEN   = 2,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          active,
  output logic          hs_act,
  output logic          vs_act
);
  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;
  logic          line_end;

  assign line_end = (hcnt == HW'(H_TOTAL - 1));

  always_comb begin
    h_nxt = hcnt + HW'(1);
    v_nxt = vcnt;
    if (line_end) begin
      h_nxt = '0;
      v_nxt = (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + VW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_nxt;
      vcnt <= v_nxt;
    end
  end

  assign active = (hcnt < HW'(H_ACTIVE)) && (vcnt < VW'(V_ACTIVE));
  assign hs_act = (hcnt >= HW'(HS_START)) && (hcnt < HW'(HS_START + HS_LEN));
  assign vs_act = (vcnt >= VW'(VS_START)) && (vcnt < VW'(VS_START + VS_LEN));
endmodule

// File: rtl/vdu_rowmap.sv
`timescale 1ns/1ps
module vdu_rowmap #(
  parameter int ROWS = 25,
  localparam int RW = $clog2(ROWS)
) (
  input  logic [RW-1:0] scr_row,
  input  logic [RW-1:0] offs,
  output logic [RW-1:0] mem_row
);
  logic [RW:0] sum;
  logic [RW:0] wrapped;

  // one extra bit so that the sum never folds before the compare
  always_comb begin
    sum     = {1'b0, scr_row} + {1'b0, offs};
    wrapped = sum - (RW+1)'(ROWS);
    mem_row = (sum >= (RW+1)'(ROWS)) ? wrapped[RW-1:0] : sum[RW-1:0];
  end
endmodule

// File: rtl/vdu_regs.sv
`timescale 1ns/1ps
module vdu_regs
  import vdu_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_data,
  output logic [CW-1:0] cur_col,
  output logic [RW-1:0] cur_row,
  output logic [RW-1:0] offs,
  output logic          char_we,
  output logic          attr_we
);
  logic [CW-1:0] col_nxt;
  logic [RW-1:0] row_nxt;
  logic [RW-1:0] offs_nxt;

  always_comb begin
    col_nxt  = cur_col;
    row_nxt  = cur_row;
    offs_nxt = offs;
    char_we  = 1'b0;
    attr_we  = 1'b0;
    if (reg_wr) begin
      case (reg_sel)
        SEL_CHAR: char_we = 1'b1;
        SEL_ATTR: attr_we = 1'b1;
        SEL_COL:  if (int'(reg_data) < COLS) col_nxt  = CW'(reg_data);
        SEL_ROW:  if (int'(reg_data) < ROWS) row_nxt  = RW'(reg_data);
        SEL_OFFS: if (int'(reg_data) < ROWS) offs_nxt = RW'(reg_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_col <= '0;
      cur_row <= '0;
      offs    <= '0;
    end else if (reg_wr) begin
      cur_col <= col_nxt;
      cur_row <= row_nxt;
      offs    <= offs_nxt;
    end
  end
endmodule

// File: rtl/vdu_dispmem.sv
`timescale 1ns/1ps
module vdu_dispmem #(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int DEPTH = COLS * ROWS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          char_we,
  input  logic          attr_we,
  input  logic [AW-1:0] wr_addr,
  input  logic [6:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [6:0]    rd_char,
  output logic [5:0]    rd_attr
);
  logic [6:0] char_ram [DEPTH];
  logic [5:0] attr_ram [DEPTH];

  always_ff @(posedge clk) begin
    if (char_we) char_ram[wr_addr] <= wr_data;
    if (attr_we) attr_ram[wr_addr] <= wr_data[5:0];
    rd_char <= char_ram[rd_addr];
    rd_attr <= attr_ram[rd_addr];
  end
endmodule

// File: rtl/vdu_top.sv
`timescale 1ns/1ps
module vdu_top
  import vdu_pkg::*;
#(
  parameter int COLS     = 80,
  parameter int ROWS     = 25,
  parameter int H_TOTAL  = 800,
  parameter int HS_START = 656,
  parameter int HS_LEN   = 96,
  parameter int V_TOTAL  = 450,
  parameter int VS_START = 412,
  parameter int VS_LEN   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_data,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [2:0] rgb
);
  localparam int H_ACTIVE = COLS * CELL_W;
  localparam int V_ACTIVE = ROWS * CELL_H;
  localparam int HW  = $clog2(H_TOTAL);
  localparam int VW  = $clog2(V_TOTAL);
  localparam int CW  = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int AW  = $clog2(COLS * ROWS);
  localparam int CSH = $clog2(CELL_W);
  localparam int LSH = $clog2(CELL_H);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          active, hs_act, vs_act;

  vdu_timing #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_LEN(HS_LEN),
    .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) u_timing (
    .clk(clk), .rst_n(rst_sync_n), .hcnt(hcnt), .vcnt(vcnt),
    .active(active), .hs_act(hs_act), .vs_act(vs_act)
  );

  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row, offs;
  logic          char_we, attr_we;

  vdu_regs #(.COLS(COLS), .ROWS(ROWS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_data(reg_data), .cur_col(cur_col), .cur_row(cur_row), .offs(offs),
    .char_we(char_we), .attr_we(attr_we)
  );

  // stage 0: scrolled cell address
  logic [CW-1:0] char_col;
  logic [RW-1:0] scr_row, mem_row;
  logic [AW-1:0] rd_addr, wr_addr;

  assign char_col = active ? CW'(hcnt >> CSH) : '0;
  assign scr_row  = active ? RW'(vcnt >> LSH) : '0;

  vdu_rowmap #(.ROWS(ROWS)) u_rowmap (
    .scr_row(scr_row), .offs(offs), .mem_row(mem_row)
  );

  assign rd_addr = AW'(mem_row) * AW'(COLS) + AW'(char_col);
  assign wr_addr = AW'(cur_row) * AW'(COLS) + AW'(cur_col);

  logic [6:0] rd_char;
  logic [5:0] rd_attr;

  vdu_dispmem #(.COLS(COLS), .ROWS(ROWS)) u_mem (
    .clk(clk), .char_we(char_we), .attr_we(attr_we), .wr_addr(wr_addr),
    .wr_data(reg_data[6:0]), .rd_addr(rd_addr), .rd_char(rd_char), .rd_attr(rd_attr)
  );

  // stage 1: timing aligned with the memory read
  logic       s1_active, s1_hs, s1_vs;
  logic [2:0] s1_px;
  logic [3:0] s1_scan;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_active <= 1'b0;
      s1_hs     <= 1'b0;
      s1_vs     <= 1'b0;
      s1_px     <= '0;
      s1_scan   <= '0;
    end else begin
      s1_active <= active;
      s1_hs     <= hs_act;
      s1_vs     <= vs_act;
      s1_px     <= 3'(hcnt[CSH-1:0]);
      s1_scan   <= 4'(vcnt[LSH-1:0]);
    end
  end

  // stage 2: glyph bit and colour
  logic [GLYPH_W-1:0] glyph;
  logic [CELL_W-1:0]  row_ltr;
  logic               pix_on;
  attr_t              cell_attr;
  logic [2:0]         rgb_nxt;

  always_comb begin
    glyph     = glyph_row(rd_char, s1_scan);
    row_ltr   = {glyph, 1'b0};
    pix_on    = row_ltr[~s1_px];
    cell_attr = attr_t'(rd_attr);
    if (!s1_active)  rgb_nxt = 3'b000;
    else if (pix_on) rgb_nxt = {cell_attr.fg_r, cell_attr.fg_g, cell_attr.fg_b};
    else             rgb_nxt = {cell_attr.bg_r, cell_attr.bg_g, cell_attr.bg_b};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rgb     <= 3'b000;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      rgb     <= rgb_nxt;
      hsync_n <= ~s1_hs;
      vsync_n <= ~s1_vs;
    end
  end
endmodule

// File: rtl/vdu_checker.sv
`timescale 1ns/1ps
module vdu_checker #(
  parameter int COLS     = 80,
  parameter int ROWS     = 25,
  parameter int H_TOTAL  = 800,
  parameter int HS_LEN   = 96,
  parameter int V_TOTAL  = 450,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [2:0]    rgb,
  input logic [CW-1:0] cur_col,
  input logic [RW-1:0] cur_row,
  input logic [RW-1:0] offs,
  input logic [RW-1:0] mem_row,
  input logic          active0
);
  logic prev_hs, prev_vs, hs_seen, vs_seen;
  int   since_hs, since_vs, hs_low_run;
  logic hs_fall, hs_rise, vs_fall;

  assign hs_fall = prev_hs && !hsync_n;
  assign hs_rise = !prev_hs && hsync_n;
  assign vs_fall = prev_vs && !vsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hs    <= 1'b1;
      prev_vs    <= 1'b1;
      hs_seen    <= 1'b0;
      vs_seen    <= 1'b0;
      since_hs   <= 0;
      since_vs   <= 0;
      hs_low_run <= 0;
    end else begin
      prev_hs    <= hsync_n;
      prev_vs    <= vsync_n;
      if (hs_fall) hs_seen <= 1'b1;
      if (vs_fall) vs_seen <= 1'b1;
      since_hs   <= hs_fall ? 0 : since_hs + 1;
      since_vs   <= vs_fall ? 0 : since_vs + 1;
      hs_low_run <= hsync_n ? 0 : hs_low_run + 1;
    end
  end

  // R1
  a_r1_line_period: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fall && hs_seen) |-> (since_hs == H_TOTAL - 1))
    else $error("line period wrong");

  // R1
  a_r1_hs_width: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && hs_seen) |-> (hs_low_run == HS_LEN))
    else $error("hsync width wrong");

  // R2
  a_r2_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_fall && vs_seen) |-> (since_vs == H_TOTAL * V_TOTAL - 1))
    else $error("frame period wrong");

  // R3
  a_r3_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> (rgb == 3'b000))
    else $error("colour during sync");

  // R4
  a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active0 |-> (int'(mem_row) < ROWS))
    else $error("scrolled row out of range");

  // R6
  a_r6_regs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_col) < COLS) && (int'(cur_row) < ROWS) && (int'(offs) < ROWS))
    else $error("cursor or offset out of range");
endmodule

bind vdu_top vdu_checker #(
  .COLS(COLS), .ROWS(ROWS), .H_TOTAL(H_TOTAL), .HS_LEN(HS_LEN), .V_TOTAL(V_TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb),
  .cur_col(cur_col), .cur_row(cur_row), .offs(offs), .mem_row(mem_row), .active0(active)
);

// File: tb/tb_vdu_top.sv
`timescale 1ns/1ps
module tb_vdu_top;
  import vdu_pkg::*;

  localparam int COLS = 4, ROWS = 25;
  localparam int H_TOTAL = 40, HS_START = 33, HS_LEN = 4;
  localparam int V_TOTAL = 410, VS_START = 402, VS_LEN = 2;
  localparam int AXW = COLS * 8, AYH = ROWS * 16;
  localparam int FRAME = H_TOTAL * V_TOTAL;
  localparam int PRE = V_TOTAL - VS_START;
  localparam int NTAB = 4;
  // {offset written, offset in effect}
  localparam int OFFS_TAB [NTAB][2] = '{'{0, 0}, '{13, 13}, '{24, 24}, '{30, 24}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_sel;
  logic [7:0] reg_data;
  logic       hsync_n, vsync_n;
  logic [2:0] rgb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int exp_char [COLS*ROWS];
  int exp_attr [COLS*ROWS];
  logic [2:0] frame [AYH][AXW];

  always #2.5 clk = ~clk;

  vdu_top #(
    .COLS(COLS), .ROWS(ROWS), .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_LEN(HS_LEN),
    .V_TOTAL(V_TOTAL), .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_data(reg_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_data = 8'(data);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic int cell_code(input int m, input int c);
    return (m * 4 + c + 8) % 128;
  endfunction

  function automatic int cell_attr(input int m, input int c);
    return ((((m + c) % 7) + 1) << 3) | ((m * 3 + c) % 8);
  endfunction

  function automatic int exp_pix(input int y, input int x, input int off);
    int s, r, c, p, m, k, a, bits;
    s = y / 16; r = y % 16; c = x / 8; p = x % 8;
    m = (s + off) % ROWS;
    k = exp_char[m*COLS + c];
    a = exp_attr[m*COLS + c];
    bits = (r < 11) ? ((k ^ r) & 127) : 0;
    if (p < 7 && ((bits >> (6 - p)) & 1) == 1) return (a >> 3) & 7;
    return a & 7;
  endfunction

  // read back the code shown on scan line 0 of a screen cell
  function automatic int decode(input int s, input int c, input int fg);
    int v;
    v = 0;
    for (int p = 0; p < 7; p++)
      if (int'(frame[s*16][c*8 + p]) == fg) v |= (1 << (6 - p));
    return v;
  endfunction

  task automatic capture();
    bit prev_hs, prev_vs, vs_end;
    int last_hf, first_hf, n_hf, bad_line, bad_hw, hs_run, vs_low, blank_bad, ln, x, y;
    prev_vs = vsync_n;
    forever begin
      @(negedge clk);
      if (prev_vs && !vsync_n) break;
      prev_vs = vsync_n;
    end
    prev_hs = hsync_n; prev_vs = 1'b0; vs_end = 1'b0;
    last_hf = -1; first_hf = -1; n_hf = 0; bad_line = 0; bad_hw = 0;
    hs_run = 0; vs_low = 0; blank_bad = 0;
    for (int t = 0; t <= FRAME; t++) begin
      if (t > 0) @(negedge clk);
      if (t == FRAME) begin
        vs_end = prev_vs && !vsync_n;
      end else begin
        ln = t / H_TOTAL; x = t % H_TOTAL; y = ln - PRE;
        if (y >= 0 && y < AYH && x < AXW) frame[y][x] = rgb;
        else if (rgb != 3'b000) blank_bad++;
        if (!vsync_n) vs_low++;
        if (prev_hs && !hsync_n) begin
          if (last_hf >= 0 && t - last_hf != H_TOTAL) bad_line++;
          if (first_hf < 0) first_hf = t;
          last_hf = t; n_hf++;
        end
        if (!hsync_n) hs_run++;
        else begin
          if (!prev_hs && hs_run != HS_LEN) bad_hw++;
          hs_run = 0;
        end
        prev_hs = hsync_n;
        prev_vs = vsync_n;
      end
    end
    chk(bad_line == 0 && n_hf == V_TOTAL && first_hf == HS_START,
        "R1 line period", n_hf, V_TOTAL);
    chk(bad_hw == 0, "R1 hsync width", bad_hw, 0);
    chk(vs_end, "R2 frame period", int'(vs_end), 1);
    chk(vs_low == VS_LEN * H_TOTAL, "R2 vsync width", vs_low, VS_LEN * H_TOTAL);
    chk(blank_bad == 0, "R3 blank black", blank_bad, 0);
  endtask

  task automatic verify(input int off);
    int mism, fa, fe, s, bgc;
    mism = 0; fa = 0; fe = 0;
    for (int y = 0; y < AYH; y++)
      for (int x = 0; x < AXW; x++)
        if (int'(frame[y][x]) != exp_pix(y, x, off)) begin
          if (mism == 0) begin fa = int'(frame[y][x]); fe = exp_pix(y, x, off); end
          mism++;
        end
    chk(mism == 0, $sformatf("R4 scrolled image offset %0d (%0d bad px)", off, mism), fa, fe);
    // R7: glyph lines 11..15 and column 7 show background
    s = 0; bgc = exp_attr[((s + off) % ROWS) * COLS] & 7;
    mism = 0;
    for (int r = 11; r < 16; r++)
      for (int p = 0; p < 8; p++)
        if (int'(frame[s*16 + r][p]) != bgc) mism++;
    for (int r = 0; r < 11; r++)
      if (int'(frame[s*16 + r][7]) != bgc) mism++;
    chk(mism == 0, "R7 unlit glyph area", mism, 0);
    // R5 R6: char written at (col 2,row 3) despite rejected cursor writes, bit 7 dropped
    s = (3 - off + ROWS) % ROWS;
    chk(decode(s, 2, (cell_attr(3, 2) >> 3) & 7) == 8'h45, "R5 R6 cursor write",
        decode(s, 2, (cell_attr(3, 2) >> 3) & 7), 8'h45);
    // R8: attribute-only write at (col 1,row 5)
    s = (5 - off + ROWS) % ROWS;
    chk(int'(frame[s*16][8 + 7]) == 2, "R8 background triple", int'(frame[s*16][15]), 2);
    chk(int'(frame[s*16][8 + 2]) == 5, "R8 foreground triple", int'(frame[s*16][10]), 5);
    chk(decode(s, 1, 5) == cell_code(5, 1), "R8 char kept", decode(s, 1, 5), cell_code(5, 1));
    // R9: first char write went to cursor (0,0)
    s = (ROWS - off) % ROWS;
    chk(decode(s, 0, (cell_attr(0, 0) >> 3) & 7) == 8'h33, "R9 reset cursor",
        decode(s, 0, (cell_attr(0, 0) >> 3) & 7), 8'h33);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 3'd0; reg_data = 8'd0;
    repeat (3) @(negedge clk);
    chk(hsync_n === 1'b1 && vsync_n === 1'b1 && rgb === 3'b000, "R9 reset outputs",
        int'({hsync_n, vsync_n, rgb}), 24);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: no cursor write yet, so this lands in cell (0,0)
    wr(SEL_CHAR, 8'h33);
    exp_char[0] = 8'h33;

    for (int m = 0; m < ROWS; m++)
      for (int c = 0; c < COLS; c++) begin
        wr(SEL_COL, c);
        wr(SEL_ROW, m);
        if (!(m == 0 && c == 0)) begin
          wr(SEL_CHAR, cell_code(m, c));
          exp_char[m*COLS + c] = cell_code(m, c);
        end
        wr(SEL_ATTR, cell_attr(m, c));
        exp_attr[m*COLS + c] = cell_attr(m, c);
      end

    // R6: rejected cursor values; R5: unused select codes
    wr(SEL_COL, 2);
    wr(SEL_ROW, 3);
    wr(SEL_COL, COLS);
    wr(SEL_ROW, ROWS);
    wr(SEL_ROW, 31);
    wr(3'd7, 8'h15);
    wr(3'd5, 8'h01);
    wr(SEL_CHAR, 8'hC5);
    exp_char[3*COLS + 2] = 8'h45;

    // R8: attribute only, upper bits dropped
    wr(SEL_COL, 1);
    wr(SEL_ROW, 5);
    wr(SEL_ATTR, 8'hEA);
    exp_attr[5*COLS + 1] = 8'h2A;

    for (int i = 0; i < NTAB; i++) begin
      wr(SEL_OFFS, OFFS_TAB[i][0]);
      capture();
      verify(OFFS_TAB[i][1]);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule